// File: doc/BRIEF.md
# Flash Completion Polling Controller

This block sits on the host side of a flash memory and waits for a program or erase operation that the device is running on its own. Once started, it reads a status word from a chosen address inside the bank being modified, over and over. Each read is judged on two bits. The completion bit is compared against the value the finished operation would leave behind. The error bit reports that the device ran past its internal time limit.

A match on the completion bit ends the wait with a pass. A mismatch with the error bit clear leads to another read. A mismatch with the error bit set leads to exactly one confirming read. That read decides the outcome: a match is a pass and a mismatch is a fail. The host also sets a maximum number of regular reads, so a device that never finishes cannot hold the controller forever.

The memory side is a simple request/acknowledge read port. On the host side there is a start pulse with its parameters, a busy flag, and a one-cycle done pulse that carries fail and timeout flags.

Top module: `flash_done_poller`

## Requirements
- R1: After reset the block is idle: busy_o, rd_req_o, done_o, fail_o and timeout_o are all 0.
- R2: When the block is idle, start_i is accepted at a clock edge. From the next cycle busy_o is 1, rd_req_o is 1 and rd_addr_o equals the addr_i captured at that edge.
- R3: The completion bit is bit 7 of rd_data_i and the error bit is bit 5. The expected completion value is 1 when erase_i is 1, and otherwise bit 7 of exp_data_i, both captured at start. If an acknowledged read has a matching completion bit, done_o is 1 in the next cycle with fail_o 0 and timeout_o 0.
- R4: If a regular read has a mismatching completion bit and a clear error bit, and the read budget is not used up, a further read is requested at the same address with no done pulse.
- R5: A mismatching read with the error bit set causes exactly one confirming read. The error bit of the confirming read is ignored. A match gives done with fail_o 0, a mismatch gives done with fail_o 1. In both cases timeout_o is 0.
- R6: If max_polls_i (captured at start, with 0 treated as 1) regular reads have all mismatched with a clear error bit, done_o follows with fail_o 1 and timeout_o 1.
- R7: done_o is high for exactly one cycle per accepted start. fail_o and timeout_o are valid with done_o and hold their value until the next accepted start.
- R8: start_i is ignored while busy_o is 1: the address, the expectation and the read budget in use do not change, and only one done pulse follows.
- R9: A read request stays asserted with a stable rd_addr_o until rd_ack_i is seen with it. Every cycle in which rd_req_o and rd_ack_i are both high completes one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a wait; sampled only while idle |
| erase_i | input | 1 | 1 = erase wait (expect completion bit 1) |
| exp_data_i | input | DW | Data word that was programmed |
| addr_i | input | AW | Status read address inside the busy bank |
| max_polls_i | input | CW | Regular read budget (0 acts as 1) |
| rd_req_o | output | 1 | Read request toward the memory |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read completes this cycle, data valid |
| rd_data_i | input | DW | Status word returned by the memory |
| busy_o | output | 1 | A wait is in progress |
| done_o | output | 1 | One-cycle end-of-wait pulse |
| fail_o | output | 1 | Outcome was a failure |
| timeout_o | output | 1 | Failure caused by the read budget running out |

## Verification
A start is accepted at one rising edge. busy_o, rd_req_o and rd_addr_o reflect it from the following cycle. The deciding read's acknowledge is consumed at one rising edge, and done_o, fail_o and timeout_o show the outcome in the following cycle. The bench drives the start and the acknowledge at falling edges. A behavioural model updates at the same rising edge as the design. Every output is compared with the model at the next falling edge, which is exactly the cycle in which each result is due. Each scenario also checks its own expected outcome on the cycle the done pulse is seen.

// File: rtl/flash_done_poller_pkg.sv
package flash_done_poller_pkg;

    typedef enum logic [1:0] {
        PS_IDLE    = 2'd0,
        PS_POLL    = 2'd1,
        PS_CONFIRM = 2'd2
    } poll_state_e;

    function automatic logic expect_bit(input logic erase, input logic data_bit);
        return erase ? 1'b1 : data_bit;
    endfunction

endpackage

// File: rtl/fcp_status_eval.sv
module fcp_status_eval #(
    parameter int DW       = 16,
    parameter int STAT_BIT = 7,
    parameter int ERR_BIT  = 5
) (
    input  logic [DW-1:0] word_i,
    input  logic          expect_i,
    output logic          match_o,
    output logic          err_o
);
    logic unused_bits;

    assign match_o     = (word_i[STAT_BIT] == expect_i);
    assign err_o       = word_i[ERR_BIT];
    assign unused_bits = ^word_i;
endmodule

// File: rtl/fcp_budget.sv
module fcp_budget #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic [CW-1:0] limit_i,
    input  logic          step_i,
    output logic          last_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] lim;
    } bud_t;

    bud_t b_d, b_q;
    logic [CW:0] next_cnt;

    assign next_cnt = {1'b0, b_q.cnt} + {{CW{1'b0}}, 1'b1};
    assign last_o   = (next_cnt >= {1'b0, b_q.lim});

    always_comb begin
        b_d = b_q;
        if (clear_i) begin
            b_d.cnt = '0;
            b_d.lim = (limit_i == '0) ? {{(CW-1){1'b0}}, 1'b1} : limit_i;
        end else if (step_i && !(&b_q.cnt)) begin
            b_d.cnt = next_cnt[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
    import flash_done_poller_pkg::*;
#(
    parameter int AW       = 21,
    parameter int DW       = 16,
    parameter int CW       = 16,
    parameter int STAT_BIT = 7,
    parameter int ERR_BIT  = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          erase_i,
    input  logic [DW-1:0] exp_data_i,
    input  logic [AW-1:0] addr_i,
    input  logic [CW-1:0] max_polls_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_ack_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          fail_o,
    output logic          timeout_o
);
    typedef struct packed {
        poll_state_e   st;
        logic [AW-1:0] addr;
        logic          exp_bit;
        logic          done;
        logic          fail;
        logic          tmo;
    } regs_t;

    regs_t r_d, r_q;
    logic  match, err, last, clr, step;
    logic  unused_exp;

    assign unused_exp = ^exp_data_i;

    fcp_status_eval #(.DW(DW), .STAT_BIT(STAT_BIT), .ERR_BIT(ERR_BIT)) eval_i (
        .word_i   (rd_data_i),
        .expect_i (r_q.exp_bit),
        .match_o  (match),
        .err_o    (err)
    );

    fcp_budget #(.CW(CW)) budget_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clr),
        .limit_i (max_polls_i),
        .step_i  (step),
        .last_o  (last)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        clr      = 1'b0;
        step     = 1'b0;
        unique case (r_q.st)
            PS_IDLE: begin
                if (start_i) begin
                    r_d.st      = PS_POLL;
                    r_d.addr    = addr_i;
                    r_d.exp_bit = expect_bit(erase_i, exp_data_i[STAT_BIT]);
                    r_d.fail    = 1'b0;
                    r_d.tmo     = 1'b0;
                    clr         = 1'b1;
                end
            end
            PS_POLL: begin
                if (rd_ack_i) begin
                    step = 1'b1;
                    if (match) begin
                        r_d.st   = PS_IDLE;
                        r_d.done = 1'b1;
                    end else if (err) begin
                        r_d.st = PS_CONFIRM;
                    end else if (last) begin
                        r_d.st   = PS_IDLE;
                        r_d.done = 1'b1;
                        r_d.fail = 1'b1;
                        r_d.tmo  = 1'b1;
                    end
                end
            end
            PS_CONFIRM: begin
                if (rd_ack_i) begin
                    r_d.st   = PS_IDLE;
                    r_d.done = 1'b1;
                    r_d.fail = !match;
                end
            end
            default: r_d.st = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: PS_IDLE, addr: '0, exp_bit: 1'b0, done: 1'b0, fail: 1'b0, tmo: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o    = (r_q.st != PS_IDLE);
    assign rd_req_o  = busy_o;
    assign rd_addr_o = r_q.addr;
    assign done_o    = r_q.done;
    assign fail_o    = r_q.fail;
    assign timeout_o = r_q.tmo;
endmodule

// File: rtl/flash_done_poller_chk.sv
module flash_done_poller_chk #(
    parameter int AW = 21
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          rd_req_o,
    input logic [AW-1:0] rd_addr_o,
    input logic          rd_ack_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          fail_o,
    input logic          timeout_o
);
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !rd_req_o); // R1

    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(rd_req_o && rd_ack_i)); // R3

    AST_TMO_IS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> fail_o); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(fail_o) && $stable(timeout_o))); // R7

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(rd_addr_o)); // R8

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o))); // R9
endmodule

bind flash_done_poller flash_done_poller_chk #(.AW(AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .rd_ack_i  (rd_ack_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .fail_o    (fail_o),
    .timeout_o (timeout_o)
);

// File: tb/flash_done_poller_tb_top.sv
`timescale 1ns/1ps
module flash_done_poller_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        erase_i = 1'b0;
    logic [15:0] exp_data_i = '0;
    logic [20:0] addr_i = '0;
    logic [15:0] max_polls_i = '0;
    logic        rd_req_o;
    logic [20:0] rd_addr_o;
    logic        rd_ack_i = 1'b0;
    logic [15:0] rd_data_i = '0;
    logic        busy_o, done_o, fail_o, timeout_o;

    always #5 clk = ~clk;

    flash_done_poller dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .erase_i(erase_i),
        .exp_data_i(exp_data_i), .addr_i(addr_i), .max_polls_i(max_polls_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
        .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o),
        .fail_o(fail_o), .timeout_o(timeout_o)
    );

    int    n_chk = 0;
    int    n_err = 0;
    int    cycles = 0;
    bit    fin = 1'b0;
    string cur_req = "R1";

    logic [15:0] wq[$];
    int          lat = 0;
    int          lat_cnt = 0;

    // reference model state
    bit          m_busy = 0, m_conf = 0, m_exp = 0;
    bit          e_done = 0, e_fail = 0, e_to = 0;
    logic [20:0] m_addr = '0;
    int          m_reads = 0, m_max = 1;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        fin = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // behavioural reference, same edge as the design
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_conf = 0; e_done = 0; e_fail = 0; e_to = 0;
            m_addr = '0; m_reads = 0;
        end else begin
            e_done = 0;
            if (!m_busy) begin
                if (start_i) begin
                    m_busy  = 1;
                    m_addr  = addr_i;
                    m_exp   = erase_i ? 1'b1 : exp_data_i[7];
                    m_max   = (max_polls_i == 0) ? 1 : int'(max_polls_i);
                    m_reads = 0; m_conf = 0; e_fail = 0; e_to = 0;
                end
            end else if (rd_ack_i) begin
                if (m_conf) begin
                    m_busy = 0; e_done = 1; e_fail = (rd_data_i[7] != m_exp);
                end else begin
                    m_reads++;
                    if (rd_data_i[7] == m_exp) begin
                        m_busy = 0; e_done = 1;
                    end else if (rd_data_i[5]) begin
                        m_conf = 1;
                    end else if (m_reads >= m_max) begin
                        m_busy = 0; e_done = 1; e_fail = 1; e_to = 1;
                    end
                end
            end
        end
    end

    // memory responder
    always @(negedge clk) begin
        if (rd_req_o === 1'b1) begin
            if (lat_cnt >= lat && wq.size() > 0) begin
                rd_ack_i  = 1'b1;
                rd_data_i = wq.pop_front();
                lat_cnt   = 0;
            end else begin
                rd_ack_i  = 1'b0;
                rd_data_i = '0;
                lat_cnt++;
            end
        end else begin
            rd_ack_i  = 1'b0;
            rd_data_i = '0;
            lat_cnt   = 0;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            chk("R7", "done_o", done_o, e_done);
            chk(cur_req, "busy_o", busy_o, m_busy);
            chk("R9", "rd_req_o", rd_req_o, m_busy);
            if (m_busy) chk("R2", "rd_addr_o", rd_addr_o, m_addr);
            chk(cur_req, "fail_o", fail_o, e_fail);
            chk(cur_req, "timeout_o", timeout_o, e_to);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !fin) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            finish_run();
        end
    end

    task automatic run(string tag, bit er, logic [15:0] ed, logic [20:0] a,
                       logic [15:0] mx, int l, bit x_fail, bit x_to);
        cur_req = tag;
        lat = l;
        @(negedge clk);
        erase_i = er; exp_data_i = ed; addr_i = a; max_polls_i = mx; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 300; i++) begin
            if (done_o) break;
            @(negedge clk);
        end
        chk(tag, "done seen", done_o, 1'b1);
        chk(tag, "outcome fail", fail_o, x_fail);
        chk(tag, "outcome timeout", timeout_o, x_to);
        repeat (3) @(negedge clk);
        chk("R7", "fail held", fail_o, x_fail);
        wq.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset busy", busy_o, 0);
        chk("R1", "reset req", rd_req_o, 0);
        chk("R1", "reset done", done_o, 0);
        chk("R1", "reset fail", fail_o, 0);
        chk("R1", "reset timeout", timeout_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        wq = '{16'h0080};
        run("R3", 0, 16'h0080, 21'h01F000, 16'd8, 0, 0, 0);
        wq = '{16'h0080, 16'h0080, 16'h0000};
        run("R4", 0, 16'h0000, 21'h000123, 16'd8, 2, 0, 0);
        wq = '{16'h0000, 16'h007F, 16'h0080};
        run("R3", 1, 16'h0000, 21'h100000, 16'd8, 1, 0, 0);
        wq = '{16'h0000, 16'h0020, 16'h00A0};
        run("R5", 0, 16'h0080, 21'h000400, 16'd8, 0, 0, 0);
        wq = '{16'h0020, 16'h0020, 16'h0080};
        run("R5", 0, 16'h0080, 21'h000401, 16'd8, 1, 1, 0);
        wq = '{16'h0000, 16'h0000, 16'h0000, 16'h0080};
        run("R6", 0, 16'h00FF, 21'h1FFFFF, 16'd3, 0, 1, 1);
        wq = '{16'h0000, 16'h0080};
        run("R6", 1, 16'h0000, 21'h0AAAAA, 16'd0, 2, 1, 1);

        // start pulses while busy must be ignored
        cur_req = "R8";
        wq = '{16'h0080, 16'h0000};
        lat = 3;
        @(negedge clk);
        erase_i = 0; exp_data_i = 16'h0000; addr_i = 21'h000055; max_polls_i = 16'd4;
        start_i = 1'b1;
        @(negedge clk);
        erase_i = 1; addr_i = 21'h155555; max_polls_i = 16'd1;
        repeat (2) @(negedge clk);
        start_i = 1'b0;
        chk("R8", "addr kept", rd_addr_o, 21'h000055);
        for (int i = 0; i < 100; i++) begin
            if (done_o) break;
            @(negedge clk);
        end
        chk("R8", "single done", done_o, 1);
        chk("R8", "ignored start outcome", fail_o, 0);
        repeat (4) @(negedge clk);
        chk("R8", "no second done", done_o, 0);
        chk("R8", "idle after", busy_o, 0);
        wq.delete();

        finish_run();
    end
endmodule